// File: doc/BRIEF.md
# Hardware Queue Slot Scheduler

This block lets a larger population of software-created work queues share a small pool of hardware queue slots. Software registers and unregisters queues by ID and rings a queue by writing a new write index to its doorbell address, which is the queue ID times a fixed doorbell stride. A newly registered queue takes a free slot at once when one exists. Otherwise it waits until a periodic wakeup swaps it in for a mapped queue whose slot has gone idle.

Two round-robin pointers steer the choices. One walks the active queues and picks the next unmapped queue to bring in. The other walks the slots and picks where that queue lands. Each slot reports a DMA-busy flag and an in-flight packet count. A slot can be evicted only when the flag is clear and the count is zero. For each slot the block emits a one-cycle fetch request when new work must be fetched, and a one-cycle discard pulse when the slot's context is torn down. After that pulse, outstanding dependency-signal reads for the slot are dropped and its signal values are reset.

Top module: `hwq_slot_sched`

## Requirements
- R1: Doorbell address A selects queue A/DB_SIZE. A doorbell write sets the sticky error flag and changes no state in any of these cases: A is not a multiple of DB_SIZE, A/DB_SIZE is at least NUM_Q, or the selected queue is not registered.
- R2: These commands set the sticky error flag and change no other state: register (op 1) with an ID at or above NUM_Q, register of an ID that is already registered, and unregister (op 2) of an ID that is not registered. Only reset clears the flag.
- R3: A register command places the queue in the first free slot found by scanning upward, with wrap, from the next-slot pointer. The slot's fetch request pulses in the cycle after the command.
- R4: Every mapping of queue A into slot S sets the next-queue pointer to (A+1) mod NUM_Q and the next-slot pointer to (S+1) mod NUM_SLOTS.
- R5: When a wakeup fires, the block scans from the next-queue pointer, with wrap, for a registered but unmapped queue. If none exists, the wakeup has no effect.
- R6: When no slot is free, a wakeup evicts the first slot, scanning from the next-slot pointer, whose DMA-busy flag is low and whose in-flight count is zero. The chosen queue takes that slot. When no slot is idle, no mapping changes.
- R7: Each unmapping of a slot, whether by eviction or by unregister, pulses that slot's discard output for exactly one cycle.
- R8: A valid doorbell (op 3) stores its write index for the queue. The stored value shows on the slot's write-index output while the queue is mapped, and a fetch request pulses only if the queue is mapped. Registration resets the stored index to zero.
- R9: Unregistering a mapped queue frees its slot. In the same cycle, an unmapped registered queue, chosen as in R5, is mapped into the freed slot.
- R10: When the wakeup timer is not armed and fewer queues are mapped than registered, the timer arms. The wakeup then fires WAKE_DELAY cycles later. The timer never arms while every registered queue is mapped.
- R11: After reset no slot is mapped, all pulses are low, the error flag is low and the timer is not armed.
- R12: A wakeup that falls due in a cycle carrying a command (op not 0) is held back. It fires in the first following cycle with op 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | 0 idle, 1 register, 2 unregister, 3 doorbell write |
| cmd_qid | input | QIDW | Queue ID for register and unregister |
| cmd_db_addr | input | AW | Doorbell address for doorbell writes |
| cmd_wr_idx | input | IW | New write index carried by a doorbell write |
| slot_dma_busy | input | NUM_SLOTS | DMA in progress, one bit per slot |
| slot_inflight | input | NUM_SLOTS*CW | In-flight packet count per slot, packed |
| slot_valid | output | NUM_SLOTS | Slot holds a queue |
| slot_qid | output | NUM_SLOTS*QB | Queue held by each slot, packed |
| slot_wr_idx | output | NUM_SLOTS*IW | Stored write index of each slot's queue, zero when empty |
| fetch_req | output | NUM_SLOTS | One-cycle fetch request per slot |
| discard_rd | output | NUM_SLOTS | One-cycle discard of dependency reads per slot |
| wake_armed | output | 1 | Wakeup timer is pending |
| err | output | 1 | Sticky command error |

## Verification
A corrupted mapping table shows on the slot_valid and slot_qid outputs in the cycle after the faulty update. A wrong pointer is not visible at once. It shows at the next register or wakeup, when the queue or slot chosen differs from the round-robin prediction. A missed eviction-idle check shows as a discard pulse on a slot that reported DMA or in-flight work in the cycle before. A stale count of mapped and registered queues shows as wake_armed arming or staying low against the prediction within one cycle. Because every output is compared with a bench model every cycle, each such divergence is caught in the first cycle it reaches a port.

// File: rtl/hwq_slot_sched.sv
module hwq_slot_sched #(
  parameter int NUM_Q      = 8,
  parameter int NUM_SLOTS  = 4,
  parameter int DB_SIZE    = 8,
  parameter int AW         = 8,
  parameter int IW         = 16,
  parameter int CW         = 4,
  parameter int WAKE_DELAY = 20,
  parameter int QB   = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  parameter int QIDW = QB + 1,
  parameter int SB   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  parameter int TW   = (WAKE_DELAY > 1) ? $clog2(WAKE_DELAY) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              cmd_op,
  input  logic [QIDW-1:0]         cmd_qid,
  input  logic [AW-1:0]           cmd_db_addr,
  input  logic [IW-1:0]           cmd_wr_idx,
  input  logic [NUM_SLOTS-1:0]    slot_dma_busy,
  input  logic [NUM_SLOTS*CW-1:0] slot_inflight,
  output logic [NUM_SLOTS-1:0]    slot_valid,
  output logic [NUM_SLOTS*QB-1:0] slot_qid,
  output logic [NUM_SLOTS*IW-1:0] slot_wr_idx,
  output logic [NUM_SLOTS-1:0]    fetch_req,
  output logic [NUM_SLOTS-1:0]    discard_rd,
  output logic                    wake_armed,
  output logic                    err
);
  localparam logic [1:0] OP_NONE = 2'd0, OP_REG = 2'd1, OP_UNREG = 2'd2, OP_DB = 2'd3;

  logic [NUM_Q-1:0]     act_r, qv_r, n_act, n_qv;
  logic [SB-1:0]        qslot_r [NUM_Q];
  logic [SB-1:0]        n_qslot [NUM_Q];
  logic [IW-1:0]        wr_r [NUM_Q];
  logic [IW-1:0]        n_wr [NUM_Q];
  logic [NUM_SLOTS-1:0] sv_r, n_sv, fetch_r, disc_r, fetch_d, disc_d;
  logic [QB-1:0]        sq_r [NUM_SLOTS];
  logic [QB-1:0]        n_sq [NUM_SLOTS];
  logic [QB-1:0]        na_r, n_na;
  logic [SB-1:0]        ns_r, n_ns;
  logic                 armed_r, n_armed, err_r, n_err;
  logic [TW-1:0]        cnt_r, n_cnt;

  wire [QB-1:0] qi     = cmd_qid[QB-1:0];
  wire          qid_ok = int'(cmd_qid) < NUM_Q;
  wire          db_ok  = (int'(cmd_db_addr) % DB_SIZE == 0) && (int'(cmd_db_addr) / DB_SIZE < NUM_Q);
  wire [QB-1:0] dq     = QB'(int'(cmd_db_addr) / DB_SIZE);
  wire          fire   = armed_r && cnt_r == '0 && cmd_op == OP_NONE;

  always_comb begin
    int a, s, mq, fs, is;
    logic cs;
    n_act = act_r; n_qv = qv_r; n_qslot = qslot_r; n_wr = wr_r;
    n_sv = sv_r; n_sq = sq_r; n_na = na_r; n_ns = ns_r;
    n_armed = armed_r; n_cnt = cnt_r; n_err = err_r;
    fetch_d = '0; disc_d = '0;
    cs = fire; mq = -1; fs = -1; is = -1; a = 0; s = 0;
    if (armed_r) begin
      if (fire) n_armed = 1'b0;
      else if (cnt_r != '0) n_cnt = cnt_r - 1'b1;
    end
    case (cmd_op)
      OP_REG: begin
        if (!qid_ok || act_r[qi]) n_err = 1'b1;
        else begin
          n_act[qi] = 1'b1;
          n_wr[qi] = '0;
          mq = int'(qi);
        end
      end
      OP_UNREG: begin
        if (!qid_ok || !act_r[qi]) n_err = 1'b1;
        else begin
          n_act[qi] = 1'b0;
          if (qv_r[qi]) begin
            n_qv[qi] = 1'b0;
            n_sv[qslot_r[qi]] = 1'b0;
            disc_d[qslot_r[qi]] = 1'b1;
            cs = 1'b1;
          end
        end
      end
      OP_DB: begin
        if (!db_ok || !act_r[dq]) n_err = 1'b1;
        else begin
          n_wr[dq] = cmd_wr_idx;
          if (qv_r[dq]) fetch_d[qslot_r[dq]] = 1'b1;
        end
      end
      default: ;
    endcase
    if (cs) begin
      for (int k = 0; k < NUM_Q; k++) begin
        a = int'(na_r) + k;
        if (a >= NUM_Q) a = a - NUM_Q;
        if (mq < 0 && n_act[a[QB-1:0]] && !n_qv[a[QB-1:0]]) mq = a;
      end
      if (mq >= 0) n_na = mq[QB-1:0];
    end
    if (mq >= 0) begin
      for (int k = 0; k < NUM_SLOTS; k++) begin
        s = int'(ns_r) + k;
        if (s >= NUM_SLOTS) s = s - NUM_SLOTS;
        if (fs < 0 && !n_sv[s[SB-1:0]]) fs = s;
        if (is < 0 && !slot_dma_busy[s[SB-1:0]] && slot_inflight[s*CW +: CW] == '0) is = s;
      end
      if (fs < 0 && cs && is >= 0) begin
        n_qv[n_sq[is[SB-1:0]]] = 1'b0;
        disc_d[is[SB-1:0]] = 1'b1;
        fs = is;
      end
      if (fs >= 0) begin
        n_sv[fs[SB-1:0]] = 1'b1;
        n_sq[fs[SB-1:0]] = mq[QB-1:0];
        n_qv[mq[QB-1:0]] = 1'b1;
        n_qslot[mq[QB-1:0]] = fs[SB-1:0];
        fetch_d[fs[SB-1:0]] = 1'b1;
        n_na = (mq == NUM_Q - 1) ? '0 : QB'(mq + 1);
        n_ns = (fs == NUM_SLOTS - 1) ? '0 : SB'(fs + 1);
      end
    end
    if (!n_armed && $countones(n_sv) < $countones(n_act)) begin
      n_armed = 1'b1;
      n_cnt = TW'(WAKE_DELAY - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_r <= '0; qv_r <= '0; sv_r <= '0; fetch_r <= '0; disc_r <= '0;
      na_r <= '0; ns_r <= '0; armed_r <= 1'b0; cnt_r <= '0; err_r <= 1'b0;
      for (int q = 0; q < NUM_Q; q++) begin qslot_r[q] <= '0; wr_r[q] <= '0; end
      for (int q = 0; q < NUM_SLOTS; q++) sq_r[q] <= '0;
    end else begin
      act_r <= n_act; qv_r <= n_qv; qslot_r <= n_qslot; wr_r <= n_wr;
      sv_r <= n_sv; sq_r <= n_sq; na_r <= n_na; ns_r <= n_ns;
      armed_r <= n_armed; cnt_r <= n_cnt; err_r <= n_err;
      fetch_r <= fetch_d; disc_r <= disc_d;
    end
  end

  assign slot_valid = sv_r;
  assign fetch_req  = fetch_r;
  assign discard_rd = disc_r;
  assign wake_armed = armed_r;
  assign err        = err_r;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign slot_qid[g*QB +: QB]    = sq_r[g];
    assign slot_wr_idx[g*IW +: IW] = sv_r[g] ? wr_r[sq_r[g]] : '0;

    assert_fetch_on_mapped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_r[g] |-> sv_r[g]);
    assert_discard_was_mapped_R7: assert property (@(posedge clk) disable iff (!rst_n)
      disc_r[g] |-> $past(sv_r[g]));
    assert_map_links_agree_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sv_r[g] |-> (qv_r[sq_r[g]] && act_r[sq_r[g]] && qslot_r[sq_r[g]] == SB'(g)));
    assert_evict_only_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (disc_r[g] && sv_r[g] && $past(cmd_op) == OP_NONE)
        |-> $past(!slot_dma_busy[g] && slot_inflight[g*CW +: CW] == '0));
  end

  assert_err_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_r |=> err_r);
  assert_arm_needs_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_r) |-> ($countones(sv_r) < $countones(act_r)));
endmodule

// File: tb/hwq_slot_sched_tb_top.sv
module hwq_slot_sched_tb_top;
  localparam int NQ = 8, NS = 4, DB = 8, AW = 8, IW = 16, CW = 4, WD = 20;
  localparam int QB = 3, QIDW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [QIDW-1:0] cmd_qid = '0;
  logic [AW-1:0] cmd_db_addr = '0;
  logic [IW-1:0] cmd_wr_idx = '0;
  logic [NS-1:0] slot_dma_busy = '0;
  logic [NS*CW-1:0] slot_inflight = '0;
  logic [NS-1:0] slot_valid, fetch_req, discard_rd;
  logic [NS*QB-1:0] slot_qid;
  logic [NS*IW-1:0] slot_wr_idx;
  logic wake_armed, err;

  always #10 clk = ~clk;

  hwq_slot_sched #(.NUM_Q(NQ), .NUM_SLOTS(NS), .DB_SIZE(DB), .AW(AW), .IW(IW),
    .CW(CW), .WAKE_DELAY(WD)) dut_i (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  int m_act[NQ], m_qv[NQ], m_qs[NQ], m_wr[NQ], m_sv[NS], m_sq[NS];
  int m_na, m_ns, m_armed, m_cnt, m_err;
  logic [NS-1:0] e_fetch, e_disc;

  function automatic int popc_s();
    int c = 0;
    for (int i = 0; i < NS; i++) c += m_sv[i];
    return c;
  endfunction
  function automatic int popc_a();
    int c = 0;
    for (int i = 0; i < NQ; i++) c += m_act[i];
    return c;
  endfunction

  task automatic m_map(int q, int s);
    m_sv[s] = 1; m_sq[s] = q; m_qv[q] = 1; m_qs[q] = s; e_fetch[s] = 1'b1;
    m_na = (q + 1) % NQ; m_ns = (s + 1) % NS;
  endtask

  task automatic model_step();
    int op = int'(cmd_op), q = int'(cmd_qid), ad = int'(cmd_db_addr);
    int mq = -1, fs = -1, is = -1, cs, fire;
    e_fetch = '0; e_disc = '0;
    fire = (m_armed && m_cnt == 0 && op == 0);
    cs = fire;
    if (m_armed) begin
      if (fire) m_armed = 0; else if (m_cnt != 0) m_cnt--;
    end
    if (op == 1) begin
      if (q >= NQ || m_act[q]) m_err = 1;
      else begin m_act[q] = 1; m_wr[q] = 0; mq = q; end
    end else if (op == 2) begin
      if (q >= NQ || !m_act[q]) m_err = 1;
      else begin
        m_act[q] = 0;
        if (m_qv[q]) begin m_qv[q] = 0; m_sv[m_qs[q]] = 0; e_disc[m_qs[q]] = 1'b1; cs = 1; end
      end
    end else if (op == 3) begin
      if (ad % DB != 0 || ad / DB >= NQ || !m_act[ad / DB]) m_err = 1;
      else begin
        m_wr[ad / DB] = int'(cmd_wr_idx);
        if (m_qv[ad / DB]) e_fetch[m_qs[ad / DB]] = 1'b1;
      end
    end
    if (cs) begin
      for (int k = 0; k < NQ; k++) begin
        int a = (m_na + k) % NQ;
        if (mq < 0 && m_act[a] && !m_qv[a]) mq = a;
      end
      if (mq >= 0) m_na = mq;
    end
    if (mq >= 0) begin
      for (int k = 0; k < NS; k++) begin
        int s = (m_ns + k) % NS;
        if (fs < 0 && !m_sv[s]) fs = s;
        if (is < 0 && !slot_dma_busy[s] && slot_inflight[s*CW +: CW] == 0) is = s;
      end
      if (fs < 0 && cs && is >= 0) begin m_qv[m_sq[is]] = 0; e_disc[is] = 1'b1; fs = is; end
      if (fs >= 0) m_map(mq, fs);
    end
    if (!m_armed && popc_s() < popc_a()) begin m_armed = 1; m_cnt = WD - 1; end
  endtask

  task automatic compare(string tag);
    bit bad = 0;
    for (int s = 0; s < NS; s++) begin
      if (slot_valid[s] !== 1'(m_sv[s])) bad = 1;
      if (m_sv[s] && int'(slot_qid[s*QB +: QB]) != m_sq[s]) bad = 1;
      if (int'(slot_wr_idx[s*IW +: IW]) != (m_sv[s] ? m_wr[m_sq[s]] : 0)) bad = 1;
    end
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s mapping: valid=%b qid=%h wr=%h, expected valid=%b%b%b%b", tag,
        slot_valid, slot_qid, slot_wr_idx, m_sv[3][0], m_sv[2][0], m_sv[1][0], m_sv[0][0]);
    end
    checks++;
    if (fetch_req !== e_fetch || discard_rd !== e_disc) begin
      fails++;
      $display("FAIL %s pulses: fetch=%b discard=%b, expected fetch=%b discard=%b", tag,
        fetch_req, discard_rd, e_fetch, e_disc);
    end
    checks++;
    if (wake_armed !== 1'(m_armed) || err !== 1'(m_err)) begin
      fails++;
      $display("FAIL %s status: armed=%b err=%b, expected armed=%0d err=%0d", tag,
        wake_armed, err, m_armed, m_err);
    end
  endtask

  task automatic cyc(int op, int q, int ad, int w, string tag);
    cmd_op = 2'(op); cmd_qid = QIDW'(q); cmd_db_addr = AW'(ad); cmd_wr_idx = IW'(w);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, tag);
  endtask

  initial begin
    for (int i = 0; i < NQ; i++) begin m_act[i] = 0; m_qv[i] = 0; m_qs[i] = 0; m_wr[i] = 0; end
    for (int i = 0; i < NS; i++) begin m_sv[i] = 0; m_sq[i] = 0; end
    m_na = 0; m_ns = 0; m_armed = 0; m_cnt = 0; m_err = 0; e_fetch = '0; e_disc = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R11");
    for (int q = 0; q < 4; q++) cyc(1, q, 0, 0, "R3");
    cyc(1, 5, 0, 0, "R10");
    cyc(1, 6, 0, 0, "R10");
    cyc(3, 8, 8, 16'h1234, "R8");
    cyc(3, 40, 40, 16'h0055, "R8");
    slot_dma_busy = 4'hF;
    idle(WD + 3, "R6");
    slot_dma_busy = 4'b1011;
    idle(WD + 3, "R5");
    slot_dma_busy = '0; slot_inflight = 16'h0300;
    idle(WD + 2, "R6");
    cyc(2, 1, 0, 0, "R9");
    cyc(2, 2, 0, 0, "R7");
    idle(WD + 2, "R10");
    cyc(3, 3, 3, 7, "R1");
    cyc(3, 200, 200, 7, "R1");
    cyc(1, 9, 0, 0, "R2");
    cyc(1, 0, 0, 0, "R2");
    cyc(2, 7, 0, 0, "R2");
    for (int q = 1; q < 8; q++) cyc(1, q, 0, 0, "R4");
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom % 16);
      int q = int'($urandom % 10);
      int ad = ($urandom % 2 == 0) ? q * DB : int'($urandom % 256);
      slot_dma_busy = NS'($urandom % 16) & NS'($urandom % 16);
      slot_inflight = ($urandom % 2 == 0) ? '0 : (NS*CW)'($urandom) & 16'h1111;
      if (r < 9) cyc(0, 0, 0, 0, (i < 1500) ? "R12" : "R5");
      else if (r < 11) cyc(1, q, 0, 0, "R4");
      else if (r < 13) cyc(2, q, 0, 0, "R9");
      else cyc(3, q, ad, int'($urandom % 65536), "R8");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule